// File: doc/BRIEF.md
# Bus Terminal Error Status Register

This block collects the fault indications of a serial command/response bus terminal that can act either as a remote terminal (RT) or as the bus controller (BC). Single-cycle error pulses come from the receive decoder, the loopback comparator and the subsystem data-transfer logic. Each one is latched into a fixed bit of a 16-bit register that holds its value until a clearing event. A parallel read port shows the register.

Three microsecond watchdogs run inside the block: one on transmitter on-time, one on a single DMA data transfer, and one on a BC transaction. A fourth counter times the subsystem's handshake acknowledge. All four count a 1 µs tick, which a prescaler derives from the system clock. When the transmitter on-time watchdog fires, the block forces the transmitter enable off until the transmit request drops. The low nibble is encoded so that software can tell a waveform fault, a parity fault and an address fault apart.

Top module: `term_err_status`

## Requirements
- R1: After power-on reset (`rst_n` low), `err_reg` reads 0 and `tx_en` is 0. Bits 15..9 always read 0.
- R2: `reg_clr_cmd`, `io_reset_cmd` and `xfer_start` while `bc_mode`=1 each clear `err_reg` to 0 at the next clock edge. This clear wins over any error that arrives in the same cycle. `xfer_start` with `bc_mode`=0 does not clear.
- R3: A bit that is set stays set until a clearing event.
- R4: `manch_err`, `sync_err` and `contig_err` each set bit 2, so bits 3..0 read 0100. `par_err` sets bits 2 and 1, so bits 3..0 read 0110. `rt_addr_err` sets bits 3 and 0, so bits 3..0 read 1xx1.
- R5: `loop_fail` (an encoding error in the terminal's own looped-back transmission) sets bit 3.
- R6: Bit 4 is set when `dma_req` stays high without `dma_ack` for `ACK_LIMIT_US` µs. An acknowledge that comes earlier leaves bit 4 clear.
- R7: Bit 5 is set when `tx_active` stays high for `TX_LIMIT_US` µs (default 680). In the same edge, `tx_en` is forced to 0 and stays 0 until `tx_active` falls. A `tx_selftest_fail` pulse also sets bit 5.
- R8: Bit 6 is set when `dma_busy` stays high for `DMA_LIMIT_US` µs (default 80). A shorter transfer leaves bit 6 clear.
- R9: `dbc_accept` sets bit 7 only when `bc_mode`=0. In BC mode it has no effect.
- R10: In BC mode, bit 8 is set `XACT_LIMIT_US` µs (default 780) after `xfer_start` if `xfer_done` has not come. An `xfer_done` that comes earlier, or leaving BC mode, cancels the timer.
- R11: Every watchdog fires after at least (L-1)·`CLK_PER_US` and at most L·`CLK_PER_US`+1 clock edges of its run condition, where L is its limit in µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reg_clr_cmd | input | 1 | Register-clear command pulse |
| io_reset_cmd | input | 1 | I/O reset command pulse; also restarts the watchdogs |
| bc_mode | input | 1 | 1 = bus controller, 0 = remote terminal |
| xfer_start | input | 1 | Transfer trigger pulse |
| xfer_done | input | 1 | Transfer completed pulse |
| rt_addr_err | input | 1 | RT address parity error pulse |
| par_err | input | 1 | Command or data word parity error pulse |
| manch_err | input | 1 | Bad Manchester waveform pulse |
| sync_err | input | 1 | Bad sync pattern pulse |
| contig_err | input | 1 | Non-contiguous data pulse |
| loop_fail | input | 1 | Loopback encoding failure pulse |
| dma_req | input | 1 | DMA request to the subsystem is pending |
| dma_ack | input | 1 | Subsystem acknowledge |
| dma_busy | input | 1 | A DMA data transfer is in progress |
| tx_active | input | 1 | Transmitter on request |
| tx_selftest_fail | input | 1 | Transmitter timeout self-test failed (pulse) |
| dbc_accept | input | 1 | Dynamic bus control request accepted |
| tx_en | output | 1 | Transmitter enable after the fail-safe gate |
| err_reg | output | 16 | Error status read port |

## Verification
A clearing event and an error pulse can fall in the same cycle. In that cycle the clear must win and the register must read zero. Reset commands are also interleaved with error pulses in the directed and random phases, and every cycle is compared with a bench model that applies the clear before it ORs in new bits. A second collision occurs in BC mode, where `xfer_start` both clears the register and restarts the transaction watchdog. The bench sets a bit, issues a BC start, checks that the register cleared, and then checks that bit 8 appears only after the full window.

// File: rtl/tes_pkg.sv
package tes_pkg;
   localparam int ERR_W     = 16;
   localparam int USED_BITS = 9;

   localparam int B_ADDR  = 0;
   localparam int B_PAR   = 1;
   localparam int B_WAVE  = 2;
   localparam int B_LOOP  = 3;
   localparam int B_ACK   = 4;
   localparam int B_TXTO  = 5;
   localparam int B_DMATO = 6;
   localparam int B_DBC   = 7;
   localparam int B_XACT  = 8;

   typedef enum int {WD_TX = 0, WD_DMA = 1, WD_ACK = 2, WD_XACT = 3} wd_idx_e;
   localparam int NUM_WD = 4;
endpackage

// File: rtl/tes_usec_tick.sv
module tes_usec_tick #(
   parameter int CLK_PER_US = 200
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_PER_US < 1) begin : g_bad
         $error("CLK_PER_US must be at least 1");
      end
      if (CLK_PER_US == 1) begin : g_direct
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= 1'b1;
         end
         assign tick = tick_q;
      end else begin : g_div
         localparam int PW = $clog2(CLK_PER_US);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pre_q <= '0;
            else if (pre_q == PW'(CLK_PER_US-1)) pre_q <= '0;
            else                                 pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PW'(CLK_PER_US-1));

         // R11
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/tes_timeout.sv
module tes_timeout #(
   parameter int LIMIT_US = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic tick,
   output logic expired
);
   localparam int CW = $clog2(LIMIT_US + 1);

   generate
      if (LIMIT_US < 1) begin : g_bad
         $error("LIMIT_US must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= '0;
      else if (restart || !run)                 cnt_q <= '0;
      else if (tick && cnt_q != CW'(LIMIT_US))  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == CW'(LIMIT_US));

   // R11
   idle_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || restart) |=> !expired);

   // R11
   expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && run && !restart) |=> expired);
endmodule

// File: rtl/term_err_status.sv
module term_err_status
   import tes_pkg::*;
#(
   parameter int CLK_PER_US    = 200,
   parameter int TX_LIMIT_US   = 680,
   parameter int DMA_LIMIT_US  = 80,
   parameter int XACT_LIMIT_US = 780,
   parameter int ACK_LIMIT_US  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_clr_cmd,
   input  logic             io_reset_cmd,
   input  logic             bc_mode,
   input  logic             xfer_start,
   input  logic             xfer_done,
   input  logic             rt_addr_err,
   input  logic             par_err,
   input  logic             manch_err,
   input  logic             sync_err,
   input  logic             contig_err,
   input  logic             loop_fail,
   input  logic             dma_req,
   input  logic             dma_ack,
   input  logic             dma_busy,
   input  logic             tx_active,
   input  logic             tx_selftest_fail,
   input  logic             dbc_accept,
   output logic             tx_en,
   output logic [ERR_W-1:0] err_reg
);
   function automatic int wd_limit(input int idx);
      case (idx)
         WD_TX:   return TX_LIMIT_US;
         WD_DMA:  return DMA_LIMIT_US;
         WD_ACK:  return ACK_LIMIT_US;
         default: return XACT_LIMIT_US;
      endcase
   endfunction

   generate
      if (TX_LIMIT_US >= 800) begin : g_bad_tx
         $error("TX_LIMIT_US must stay below the 800 us bus maximum");
      end
   endgenerate

   logic                 tick;
   logic [NUM_WD-1:0]    wd_run, wd_restart, wd_exp;
   logic                 pend_q, shut_q, clr_evt, bc_start;
   logic [USED_BITS-1:0] err_q, set_vec;

   tes_usec_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   assign bc_start = xfer_start && bc_mode;
   assign clr_evt  = reg_clr_cmd || io_reset_cmd || bc_start;

   // BC transaction pending from trigger until completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 pend_q <= 1'b0;
      else if (io_reset_cmd || !bc_mode)          pend_q <= 1'b0;
      else if (bc_start)                          pend_q <= 1'b1;
      else if (xfer_done)                         pend_q <= 1'b0;
   end

   assign wd_run[WD_TX]       = tx_active;
   assign wd_run[WD_DMA]      = dma_busy;
   assign wd_run[WD_ACK]      = dma_req && !dma_ack;
   assign wd_run[WD_XACT]     = pend_q;
   assign wd_restart[WD_TX]   = io_reset_cmd;
   assign wd_restart[WD_DMA]  = io_reset_cmd;
   assign wd_restart[WD_ACK]  = io_reset_cmd;
   assign wd_restart[WD_XACT] = io_reset_cmd || bc_start;

   generate
      for (genvar g = 0; g < NUM_WD; g++) begin : g_wd
         tes_timeout #(.LIMIT_US(wd_limit(g))) u_wd (
            .clk(clk), .rst_n(rst_n), .restart(wd_restart[g]),
            .run(wd_run[g]), .tick(tick), .expired(wd_exp[g]));
      end
   endgenerate

   // fail-safe transmitter shutoff
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             shut_q <= 1'b0;
      else if (!tx_active)    shut_q <= 1'b0;
      else if (wd_exp[WD_TX]) shut_q <= 1'b1;
   end
   assign tx_en = tx_active && !shut_q;

   always_comb begin
      set_vec          = '0;
      set_vec[B_ADDR]  = rt_addr_err;
      set_vec[B_PAR]   = par_err;
      set_vec[B_WAVE]  = manch_err || sync_err || contig_err || par_err;
      set_vec[B_LOOP]  = loop_fail || rt_addr_err;
      set_vec[B_ACK]   = wd_exp[WD_ACK];
      set_vec[B_TXTO]  = wd_exp[WD_TX] || tx_selftest_fail;
      set_vec[B_DMATO] = wd_exp[WD_DMA];
      set_vec[B_DBC]   = dbc_accept && !bc_mode;
      set_vec[B_XACT]  = wd_exp[WD_XACT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= '0;
      else if (clr_evt) err_q <= '0;
      else              err_q <= err_q | set_vec;
   end

   assign err_reg = {{(ERR_W-USED_BITS){1'b0}}, err_q};

   // R2
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_clr_cmd || io_reset_cmd || (xfer_start && bc_mode)) |=> (err_reg == '0));

   // R3
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_evt |=> ((err_q & $past(err_q)) == $past(err_q)));

   // R7
   tx_shutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_exp[WD_TX] && tx_active && !clr_evt) |=> (!tx_en && err_reg[B_TXTO]));

   // R9
   dbc_bc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_mode && !err_q[B_DBC]) |=> !err_q[B_DBC]);

   // R10
   xact_rt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bc_mode |=> !pend_q);
endmodule

// File: tb/term_err_status_bench.sv
module term_err_status_bench;
   localparam int CPU  = 4;
   localparam int TXL  = 680;
   localparam int DMAL = 80;
   localparam int XL   = 780;
   localparam int ACKL = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_clr_cmd = 0, io_reset_cmd = 0, bc_mode = 0, xfer_start = 0, xfer_done = 0;
   logic rt_addr_err = 0, par_err = 0, manch_err = 0, sync_err = 0, contig_err = 0;
   logic loop_fail = 0, dma_req = 0, dma_ack = 0, dma_busy = 0, tx_active = 0;
   logic tx_selftest_fail = 0, dbc_accept = 0;
   logic tx_en;
   logic [15:0] err_reg;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q = '0;

   always #2.5 clk = ~clk;

   term_err_status #(.CLK_PER_US(CPU), .TX_LIMIT_US(TXL), .DMA_LIMIT_US(DMAL),
      .XACT_LIMIT_US(XL), .ACK_LIMIT_US(ACKL)) u_term_err_status (
      .clk(clk), .rst_n(rst_n), .reg_clr_cmd(reg_clr_cmd), .io_reset_cmd(io_reset_cmd),
      .bc_mode(bc_mode), .xfer_start(xfer_start), .xfer_done(xfer_done),
      .rt_addr_err(rt_addr_err), .par_err(par_err), .manch_err(manch_err),
      .sync_err(sync_err), .contig_err(contig_err), .loop_fail(loop_fail),
      .dma_req(dma_req), .dma_ack(dma_ack), .dma_busy(dma_busy), .tx_active(tx_active),
      .tx_selftest_fail(tx_selftest_fail), .dbc_accept(dbc_accept),
      .tx_en(tx_en), .err_reg(err_reg));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
      end
   endtask

   // expected next register value from the pulse inputs (timers idle)
   function automatic logic [15:0] model_next(input logic [15:0] cur);
      logic [15:0] s;
      if (reg_clr_cmd || io_reset_cmd || (xfer_start && bc_mode)) return 16'h0;
      s = '0;
      s[0] = rt_addr_err;
      s[1] = par_err;
      s[2] = manch_err | sync_err | contig_err | par_err;
      s[3] = loop_fail | rt_addr_err;
      s[5] = tx_selftest_fail;
      s[7] = dbc_accept & ~bc_mode;
      return cur | s;
   endfunction

   task automatic clear_pulses();
      reg_clr_cmd = 0; io_reset_cmd = 0; xfer_start = 0; xfer_done = 0;
      rt_addr_err = 0; par_err = 0; manch_err = 0; sync_err = 0; contig_err = 0;
      loop_fail = 0; tx_selftest_fail = 0; dbc_accept = 0;
   endtask

   // one clock with the current pulse inputs, then model update
   task automatic cyc();
      exp_q = model_next(exp_q);
      @(posedge clk); #1;
      clear_pulses();
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1553));
      wait_n(3);
      chk("R1 reset reg", err_reg, 16'h0);
      chk("R1 reset tx_en", {15'h0, tx_en}, 16'h0);
      rst_n = 1; wait_n(2);

      // R4 encodings
      manch_err = 1; cyc();
      chk("R4 manchester 0100", err_reg, 16'h0004);
      reg_clr_cmd = 1; cyc();
      chk("R2 reg clear", err_reg, 16'h0);
      par_err = 1; cyc();
      chk("R4 parity 0110", err_reg, 16'h0006);
      io_reset_cmd = 1; cyc();
      chk("R2 io reset clear", err_reg, 16'h0);
      rt_addr_err = 1; cyc();
      chk("R4 rt address 1xx1", err_reg, 16'h0009);
      sync_err = 1; cyc();
      chk("R3 sticky plus sync", err_reg, 16'h000D);
      reg_clr_cmd = 1; contig_err = 1; par_err = 1; cyc();
      chk("R2 clear beats error", err_reg, 16'h0);
      contig_err = 1; cyc();
      chk("R4 contig", err_reg, 16'h0004);
      reg_clr_cmd = 1; cyc();
      loop_fail = 1; cyc();
      chk("R5 loopback", err_reg, 16'h0008);
      dbc_accept = 1; cyc();
      chk("R9 dbc in RT", err_reg, 16'h0088);
      reg_clr_cmd = 1; cyc();
      bc_mode = 1; cyc();
      dbc_accept = 1; cyc();
      chk("R9 dbc ignored in BC", err_reg, 16'h0);
      bc_mode = 0; cyc();
      manch_err = 1; cyc();
      xfer_start = 1; cyc();
      chk("R2 RT start no clear", err_reg, 16'h0004);
      tx_selftest_fail = 1; cyc();
      chk("R7 selftest", err_reg, 16'h0024);
      reg_clr_cmd = 1; cyc();

      // R7 transmitter fail-safe
      tx_active = 1;
      wait_n((TXL - 1) * CPU);
      chk("R7 tx before limit", err_reg, 16'h0);
      chk("R7 tx_en before limit", {15'h0, tx_en}, 16'h1);
      wait_n(CPU + 1);
      chk("R7 tx timeout bit", err_reg, 16'h0020);
      chk("R7 tx_en forced off", {15'h0, tx_en}, 16'h0);
      tx_active = 0; wait_n(1);
      tx_active = 1; wait_n(1);
      chk("R7 tx_en restored", {15'h0, tx_en}, 16'h1);
      tx_active = 0; reg_clr_cmd = 1; wait_n(1); reg_clr_cmd = 0;

      // R8 DMA duration
      dma_busy = 1; wait_n((DMAL - 10) * CPU); dma_busy = 0; wait_n(2);
      chk("R8 short dma", err_reg, 16'h0);
      dma_busy = 1; wait_n((DMAL - 1) * CPU);
      chk("R11 dma before limit", err_reg, 16'h0);
      wait_n(CPU + 1);
      chk("R8 dma timeout", err_reg, 16'h0040);
      dma_busy = 0; reg_clr_cmd = 1; wait_n(1); reg_clr_cmd = 0;

      // R6 handshake
      dma_req = 1; wait_n(3 * CPU); dma_ack = 1; wait_n(2 * ACKL * CPU);
      chk("R6 acked in time", err_reg, 16'h0);
      dma_ack = 0; wait_n((ACKL - 1) * CPU);
      chk("R6 before limit", err_reg, 16'h0);
      wait_n(CPU + 1);
      chk("R6 handshake timeout", err_reg, 16'h0010);
      dma_req = 0; wait_n(1);

      // R10 BC transaction
      bc_mode = 1; wait_n(1);
      xfer_start = 1; wait_n(1); xfer_start = 0;
      chk("R2 BC start clears", err_reg, 16'h0);
      wait_n((XL - 1) * CPU);
      chk("R10 before limit", err_reg, 16'h0);
      wait_n(CPU + 2);
      chk("R10 transaction timeout", err_reg, 16'h0100);
      xfer_start = 1; wait_n(1); xfer_start = 0;
      wait_n((XL - 100) * CPU); xfer_done = 1; wait_n(1); xfer_done = 0;
      wait_n(200 * CPU);
      chk("R10 done cancels", err_reg, 16'h0);
      xfer_start = 1; wait_n(1); xfer_start = 0;
      wait_n(10); bc_mode = 0; wait_n((XL + 20) * CPU);
      chk("R10 mode exit cancels", err_reg, 16'h0);
      io_reset_cmd = 1; wait_n(1); io_reset_cmd = 0;
      exp_q = '0;

      // random pulses against the model
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[3:0] == 0) bc_mode = ~bc_mode;
         reg_clr_cmd = (r[9:4] == 0);
         io_reset_cmd = (r[15:10] == 1);
         xfer_start = (r[19:16] == 2);
         xfer_done = 1'b1;
         rt_addr_err = (r[24:20] == 3);
         par_err = (r[29:25] == 4);
         r = $urandom;
         manch_err = (r[4:0] == 5);
         sync_err = (r[9:5] == 6);
         contig_err = (r[14:10] == 7);
         loop_fail = (r[19:15] == 8);
         dbc_accept = (r[24:20] == 9);
         tx_selftest_fail = (r[30:25] == 10);
         cyc();
         checks++;
         if (err_reg !== exp_q) begin
            errors++;
            $display("FAIL R2/R3/R4 random: actual %h expected %h", err_reg, exp_q);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule